// File: doc/BRIEF.md
# Eight-Phase Instruction Step Sequencer

This block steps a small accumulator processor through the work of one instruction. A free-running phase counter walks through eight phases and then wraps, with no branching. The first four phases bring the next instruction word in from memory; the last four carry it out. Nine control strobes for the datapath are decoded from the current phase, the instruction opcode and the zero flag of the arithmetic unit.

The datapath, the memory, the program counter and the instruction register sit outside the block. They sample the strobes on the rising clock edge. The opcode and zero inputs are held steady ahead of each edge, and the strobes follow them combinationally within the phase.

Top module: `cpu_step_sequencer`

## Requirements
- R1: The phase starts at 0 and advances by one on every rising clock edge while reset is released, going 7 to 0 with no branching. The first rising edge after reset is released moves it from 0 to 1.
- R2: The reset input rst_n is active low and asynchronous. While it is low, all nine strobes are 0 and the phase is forced to 0. This holds at once, without waiting for a clock edge.
- R3: Opcode encoding on instr_op: 000 stop, 001 skip-if-zero, 010 add, 011 and, 100 xor, 101 load, 110 store, 111 jump.
- R4: Phase 0 drives only addr_sel_pc. Phase 1 drives mem_read and addr_sel_pc. Phases 2 and 3 drive mem_read, ir_load and addr_sel_pc. All of these ignore the opcode and the zero flag.
- R5: Phase 4 drives pc_incr for every opcode. It also drives cpu_halt when the opcode is stop (000).
- R6: Phase 5 drives mem_read for add, and, xor and load. For the other opcodes it drives no strobe.
- R7: Phase 6 drives pc_incr and bus_drive for skip-if-zero with alu_zero high. It drives mem_read for add, and, xor and load, and pc_load with bus_drive for jump. Every other case drives only bus_drive.
- R8: Phase 7 drives pc_incr and bus_drive for skip-if-zero with alu_zero high. It drives mem_read with acc_load for add, and, xor and load, mem_write with bus_drive for store, and pc_load, pc_incr and bus_drive for jump. Every other case drives only bus_drive.
- R9: mem_read and mem_write are never high together. mem_write appears only with the store opcode, cpu_halt only with stop, pc_load only with jump, and acc_load only together with mem_read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_zero | input | 1 | Zero flag from the arithmetic unit |
| instr_op | input | 3 | Opcode of the current instruction |
| mem_read | output | 1 | Memory read strobe |
| mem_write | output | 1 | Memory write strobe |
| ir_load | output | 1 | Instruction register load |
| acc_load | output | 1 | Accumulator load |
| pc_load | output | 1 | Program counter load from the operand |
| pc_incr | output | 1 | Program counter increment |
| cpu_halt | output | 1 | Halt indication |
| bus_drive | output | 1 | Drive accumulator onto the data bus |
| addr_sel_pc | output | 1 | Address mux selects the program counter |

## Verification
The bench builds the block with its default three-bit phase and opcode widths. Every phase can therefore be combined with every opcode and both zero values. The sweep runs sixteen full instructions, each opcode once with zero low and once with zero high. A stretch follows in which opcode and zero change every cycle, so that the decode is shown to follow the live inputs and not a copy latched at fetch. Two reset pulses are applied: one before the first edge and one in the middle of an instruction. Both show that the strobes clear between edges and that counting resumes at phase 0.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int PHASE_W    = 3;
    localparam int NUM_PHASES = 1 << PHASE_W;
    localparam int OPCODE_W   = 3;

    typedef enum logic [OPCODE_W-1:0] {
        OP_STOP  = 3'b000,
        OP_SKIPZ = 3'b001,
        OP_ADD   = 3'b010,
        OP_AND   = 3'b011,
        OP_XOR   = 3'b100,
        OP_LOAD  = 3'b101,
        OP_STORE = 3'b110,
        OP_JUMP  = 3'b111
    } op_t;

    typedef enum logic [PHASE_W-1:0] {
        PH_ADDR_SETUP    = 3'd0,
        PH_INSTR_FETCH   = 3'd1,
        PH_INSTR_LOAD    = 3'd2,
        PH_INSTR_HOLD    = 3'd3,
        PH_OPERAND_ADDR  = 3'd4,
        PH_OPERAND_FETCH = 3'd5,
        PH_EXECUTE       = 3'd6,
        PH_WRITEBACK     = 3'd7
    } phase_t;

    typedef struct packed {
        logic mem_read;
        logic mem_write;
        logic ir_load;
        logic acc_load;
        logic pc_load;
        logic pc_incr;
        logic cpu_halt;
        logic bus_drive;
        logic addr_sel_pc;
    } strobes_t;

    localparam strobes_t STROBES_IDLE = '0;

    // Opcodes that read an operand from memory into the accumulator
    function automatic logic reads_operand(op_t op);
        return (op == OP_ADD) || (op == OP_AND) ||
               (op == OP_XOR) || (op == OP_LOAD);
    endfunction

    function automatic logic skip_taken(op_t op, logic zero);
        return (op == OP_SKIPZ) && zero;
    endfunction

endpackage

// File: rtl/phase_counter.sv
module phase_counter
    import seq_pkg::*;
#(
    parameter int WIDTH = PHASE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] phase
);

    logic [WIDTH-1:0] phase_q;

    // Power-of-two phase count: the increment wraps naturally
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/fetch_decode.sv
module fetch_decode
    import seq_pkg::*;
(
    input  phase_t   phase,
    output strobes_t strb
);

    always_comb begin
        strb = STROBES_IDLE;
        unique case (phase)
            PH_ADDR_SETUP: begin
                strb.addr_sel_pc = 1'b1;
            end
            PH_INSTR_FETCH: begin
                strb.addr_sel_pc = 1'b1;
                strb.mem_read    = 1'b1;
            end
            PH_INSTR_LOAD, PH_INSTR_HOLD: begin
                strb.addr_sel_pc = 1'b1;
                strb.mem_read    = 1'b1;
                strb.ir_load     = 1'b1;
            end
            default: strb = STROBES_IDLE;
        endcase
    end

endmodule

// File: rtl/execute_decode.sv
module execute_decode
    import seq_pkg::*;
(
    input  phase_t   phase,
    input  op_t      op,
    input  logic     zero,
    output strobes_t strb
);

    logic rd_op;
    logic skip;

    always_comb begin
        rd_op = reads_operand(op);
        skip  = skip_taken(op, zero);
        strb  = STROBES_IDLE;
        unique case (phase)
            PH_OPERAND_ADDR: begin
                strb.pc_incr  = 1'b1;
                strb.cpu_halt = (op == OP_STOP);
            end
            PH_OPERAND_FETCH: begin
                strb.mem_read = rd_op;
            end
            PH_EXECUTE: begin
                if (skip) begin
                    strb.pc_incr   = 1'b1;
                    strb.bus_drive = 1'b1;
                end else if (rd_op) begin
                    strb.mem_read  = 1'b1;
                end else if (op == OP_JUMP) begin
                    strb.pc_load   = 1'b1;
                    strb.bus_drive = 1'b1;
                end else begin
                    strb.bus_drive = 1'b1;
                end
            end
            PH_WRITEBACK: begin
                if (skip) begin
                    strb.pc_incr   = 1'b1;
                    strb.bus_drive = 1'b1;
                end else if (rd_op) begin
                    strb.mem_read  = 1'b1;
                    strb.acc_load  = 1'b1;
                end else if (op == OP_STORE) begin
                    strb.mem_write = 1'b1;
                    strb.bus_drive = 1'b1;
                end else if (op == OP_JUMP) begin
                    strb.pc_load   = 1'b1;
                    strb.pc_incr   = 1'b1;
                    strb.bus_drive = 1'b1;
                end else begin
                    strb.bus_drive = 1'b1;
                end
            end
            default: strb = STROBES_IDLE;
        endcase
    end

endmodule

// File: rtl/cpu_step_sequencer.sv
module cpu_step_sequencer
    import seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alu_zero,
    input  logic [OPCODE_W-1:0] instr_op,
    output logic                mem_read,
    output logic                mem_write,
    output logic                ir_load,
    output logic                acc_load,
    output logic                pc_load,
    output logic                pc_incr,
    output logic                cpu_halt,
    output logic                bus_drive,
    output logic                addr_sel_pc
);

    logic [PHASE_W-1:0] phase_raw;
    phase_t             phase;
    op_t                op;
    strobes_t           fetch_strb;
    strobes_t           exec_strb;
    strobes_t           out_strb;

    phase_counter #(.WIDTH(PHASE_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase_raw)
    );

    assign phase = phase_t'(phase_raw);
    assign op    = op_t'(instr_op);

    fetch_decode u_fetch (
        .phase (phase),
        .strb  (fetch_strb)
    );

    execute_decode u_exec (
        .phase (phase),
        .op    (op),
        .zero  (alu_zero),
        .strb  (exec_strb)
    );

    // The two halves never drive strobes in the same phase; reset masks both
    always_comb begin
        if (!rst_n) begin
            out_strb = STROBES_IDLE;
        end else begin
            out_strb = fetch_strb | exec_strb;
        end
    end

    assign mem_read    = out_strb.mem_read;
    assign mem_write   = out_strb.mem_write;
    assign ir_load     = out_strb.ir_load;
    assign acc_load    = out_strb.acc_load;
    assign pc_load     = out_strb.pc_load;
    assign pc_incr     = out_strb.pc_incr;
    assign cpu_halt    = out_strb.cpu_halt;
    assign bus_drive   = out_strb.bus_drive;
    assign addr_sel_pc = out_strb.addr_sel_pc;

endmodule

// File: rtl/cpu_step_sequencer_chk.sv
module cpu_step_sequencer_chk
    import seq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                alu_zero,
    input logic [OPCODE_W-1:0] instr_op,
    input logic                mem_read,
    input logic                mem_write,
    input logic                ir_load,
    input logic                acc_load,
    input logic                pc_load,
    input logic                pc_incr,
    input logic                cpu_halt,
    input logic                bus_drive,
    input logic                addr_sel_pc
);

    // R2
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> ({mem_read, mem_write, ir_load, acc_load, pc_load,
                     pc_incr, cpu_halt, bus_drive, addr_sel_pc} == '0));

    // R9
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_read && mem_write));

    // R9
    write_store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_write |-> (instr_op == OP_STORE));

    // R5
    halt_stop_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halt |-> (instr_op == OP_STOP && pc_incr));

    // R9
    pcload_jump_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (instr_op == OP_JUMP));

    // R9
    accload_with_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_load |-> mem_read);

    // R1
    load_then_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ir_load) |-> pc_incr);

    // R4
    sel_fetch_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_sel_pc |-> !bus_drive && !pc_incr);

endmodule

bind cpu_step_sequencer cpu_step_sequencer_chk u_chk (.*);

// File: tb/tb_cpu_step_sequencer.sv
module tb_cpu_step_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alu_zero = 1'b0;
    logic [2:0] instr_op = 3'b000;
    logic mem_read, mem_write, ir_load, acc_load, pc_load;
    logic pc_incr, cpu_halt, bus_drive, addr_sel_pc;

    int n_vec  = 0;
    int n_fail = 0;
    int ref_phase = 0;

    always #2 clk = ~clk;   // 250 MHz

    cpu_step_sequencer dut (
        .clk(clk), .rst_n(rst_n), .alu_zero(alu_zero), .instr_op(instr_op),
        .mem_read(mem_read), .mem_write(mem_write), .ir_load(ir_load),
        .acc_load(acc_load), .pc_load(pc_load), .pc_incr(pc_incr),
        .cpu_halt(cpu_halt), .bus_drive(bus_drive), .addr_sel_pc(addr_sel_pc)
    );

    // Reference phase: R1 and R2
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_phase <= 0;
        else        ref_phase <= (ref_phase + 1) % 8;
    end

    // Bit order: rd wr irld accld pcld pcinc halt drive sel
    function automatic logic [8:0] expect_out(int ph, int op, logic z, logic rn);
        logic [8:0] e;
        bit memop;
        bit skip;
        memop = (op == 2) || (op == 3) || (op == 4) || (op == 5);
        skip  = (op == 1) && z;
        e = '0;
        if (!rn) return e;
        case (ph)
            0: e = 9'b000000001;
            1: e = 9'b100000001;
            2, 3: e = 9'b101000001;
            4: e = (op == 0) ? 9'b000001100 : 9'b000001000;
            5: e = memop ? 9'b100000000 : 9'b000000000;
            6: begin
                if (skip)          e = 9'b000001010;
                else if (memop)    e = 9'b100000000;
                else if (op == 7)  e = 9'b000010010;
                else               e = 9'b000000010;
            end
            default: begin
                if (skip)          e = 9'b000001010;
                else if (memop)    e = 9'b100100000;
                else if (op == 6)  e = 9'b010000010;
                else if (op == 7)  e = 9'b000011010;
                else               e = 9'b000000010;
            end
        endcase
        return e;
    endfunction

    function automatic string req_of(int ph, logic rn);
        if (!rn) return "R2";
        case (ph)
            0, 1, 2, 3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic compare(string extra);
        logic [8:0] act;
        logic [8:0] exp;
        act = {mem_read, mem_write, ir_load, acc_load, pc_load,
               pc_incr, cpu_halt, bus_drive, addr_sel_pc};
        exp = expect_out(ref_phase, int'(instr_op), alu_zero, rst_n);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s%s phase=%0d op=%0d zero=%0d actual=%b expected=%b",
                     req_of(ref_phase, rst_n), extra, ref_phase, instr_op,
                     alu_zero, act, exp);
        end
    endtask

    // Wait one edge, then set inputs and compare in mid-cycle
    task automatic step(logic [2:0] op, logic z, string extra);
        @(posedge clk);
        #1;
        instr_op = op;
        alu_zero = z;
        #0.5;
        compare(extra);
    endtask

    initial begin
        // R2: reset held, varied inputs, outputs stay quiet
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            #1;
            instr_op = 3'(i * 3);
            alu_zero = i[0];
            #0.5;
            compare(" reset-held");
        end
        // Release between edges; phase 0 seen before first edge (R1)
        #0.5;
        rst_n = 1'b1;
        instr_op = 3'b010;
        alu_zero = 1'b0;
        #0.2;
        compare(" R1 phase0-after-release");
        // R3 sweep: every opcode, both zero values, full instruction
        for (int z = 0; z < 2; z++) begin
            for (int op = 0; op < 8; op++) begin
                for (int ph = 0; ph < 8; ph++) begin
                    if (!(z == 0 && op == 0 && ph == 0))
                        step(3'(op), z[0], " R3 sweep");
                end
            end
        end
        // Live inputs changing every cycle
        for (int i = 0; i < 200; i++) begin
            step(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), " live");
        end
        // R2: asynchronous reset in the middle of an instruction
        @(posedge clk);
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        #0.2;
        compare(" async-assert");
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        instr_op = 3'b110;
        #0.2;
        compare(" R1 restart");
        for (int i = 0; i < 16; i++) step(3'b110, 1'b0, " R9 store-after-reset");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #20000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule